// File: doc/BRIEF.md
# Clock-Fail Capture Latch with Selectable Polarity and Debounce

This block watches an asynchronous clock-fail line coming from a shared backplane and records a failure in a sticky latch. The latch drives an interrupt request. A polarity input selects whether a low or a high level on the line counts as the setting level. By arming the block for one level, taking the interrupt, clearing, and then arming it for the other level, software can see both edges of a fail event.

The fail line passes through a two-flop synchronizer before any decision is made. An optional debounce filter runs on the master clock. When the filter is on, the latch sets only after the synchronized line has matched the setting level on two consecutive clock edges. The active-low clear input holds the latch empty while it is low and has priority over any set condition. Once the latch is set, it stays set until the clear input goes low.

Top module: `fail_latch`

## Requirements
- R1: With `polSel` = 0, a low level on `failLine` sets the latch, and a high level never sets it.
- R2: With `polSel` = 1, a high level on `failLine` sets the latch, and a low level never sets it.
- R3: With `dbEn` = 0, a setting level that is first presented before clock edge 1 is visible on `latched` after edge 3: two synchronizer flops, then the latch register. A level held for one clock period is enough.
- R4: With `dbEn` = 1, the latch sets only when two consecutive synchronized samples both show the setting level. A held level is visible on `latched` after edge 4. A setting level that is present for only one clock period never sets the latch.
- R5: While `clearN` = 0, `latched` is 0 after the next clock edge, whatever the level on `failLine`. Clear wins over set.
- R6: Once set, `latched` stays 1 while `clearN` = 1, even after `failLine` returns to its inactive level.
- R7: `irq` is high exactly when `latched` is high.
- R8: After reset (`rstN` = 0), `latched` and `irq` are 0.
- R9: `polSel` changes only while `clearN` is 0, both before and after the change, so a polarity switch never sets the latch by itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock. It also clocks the synchronizer and the debounce filter. |
| rstN | input | 1 | Synchronous active-low reset |
| failLine | input | 1 | Asynchronous clock-fail line from the backplane |
| polSel | input | 1 | Setting level select: 0 = set on low, 1 = set on high |
| dbEn | input | 1 | 1 = require two consecutive matching samples before setting |
| clearN | input | 1 | Active-low latch clear; holds the latch empty while low |
| latched | output | 1 | Sticky failure state |
| irq | output | 1 | Interrupt request, equal to the latch state |

## Verification
The checker assumes that `polSel` stays still while `clearN` is high on the current and the previous edge. The stimulus keeps to this rule: it changes the polarity only inside a window where clear is held low. Beyond that, the fail line, the debounce enable and the clear timing are left free. The checker relates the latch to the synchronized level, which the synchronizer provides. It does not relate the latch to the raw pin, so metastability settling is not part of any property. The random phase toggles the fail line often enough to create single-period pulses. With debounce on, these pulses must be rejected.

// File: rtl/fail_latch_pkg.sv
package fail_latch_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic setStb;   // capture a qualified failure
    logic clrStb;   // empty the latch (priority)
  } latchStb_t;

endpackage

// File: rtl/fail_latch_dp.sv
module fail_latch_dp
  import fail_latch_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DB_SAMPLES  = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      failLine,
  input  logic      polSel,
  input  latchStb_t stb,
  output logic      syncLvl,
  output logic      activeLvl,
  output logic      histAll,
  output logic      latched
);

  localparam int HIST_W = DB_SAMPLES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [HIST_W-1:0]      hist;
  logic                   latchQ;

  // Synchronizer chain
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= failLine;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], failLine};
      end
    end
  endgenerate

  assign syncLvl   = syncQ[SYNC_STAGES-1];
  assign activeLvl = (syncLvl == polSel);

  // History of earlier setting-level matches
  generate
    if (HIST_W == 1) begin : g_hist1
      always_ff @(posedge clk) begin
        if (!rstN) hist <= '0;
        else       hist <= activeLvl;
      end
    end else begin : g_histN
      always_ff @(posedge clk) begin
        if (!rstN) hist <= '0;
        else       hist <= {hist[HIST_W-2:0], activeLvl};
      end
    end
  endgenerate

  assign histAll = &hist;

  // Sticky latch; clear has priority
  always_ff @(posedge clk) begin
    if (!rstN)           latchQ <= 1'b0;
    else if (stb.clrStb) latchQ <= 1'b0;
    else if (stb.setStb) latchQ <= 1'b1;
  end

  assign latched = latchQ;

endmodule

// File: rtl/fail_latch_ctrl.sv
module fail_latch_ctrl
  import fail_latch_pkg::*;
(
  input  logic      activeLvl,
  input  logic      histAll,
  input  logic      dbEn,
  input  logic      clearN,
  input  logic      latched,
  output latchStb_t stb
);

  logic qualified;

  always_comb begin
    qualified  = activeLvl && (!dbEn || histAll);
    stb.clrStb = !clearN;
    stb.setStb = clearN && !latched && qualified;
  end

endmodule

// File: rtl/fail_latch.sv
module fail_latch
  import fail_latch_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DB_SAMPLES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic failLine,
  input  logic polSel,
  input  logic dbEn,
  input  logic clearN,
  output logic latched,
  output logic irq
);

  latchStb_t stb;
  logic      syncLvl;
  logic      activeLvl;
  logic      histAll;

  fail_latch_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .DB_SAMPLES (DB_SAMPLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .failLine (failLine),
    .polSel   (polSel),
    .stb      (stb),
    .syncLvl  (syncLvl),
    .activeLvl(activeLvl),
    .histAll  (histAll),
    .latched  (latched)
  );

  fail_latch_ctrl u_ctrl (
    .activeLvl(activeLvl),
    .histAll  (histAll),
    .dbEn     (dbEn),
    .clearN   (clearN),
    .latched  (latched),
    .stb      (stb)
  );

  assign irq = latched;

endmodule

// File: rtl/fail_latch_chk.sv
module fail_latch_chk (
  input logic clk,
  input logic rstN,
  input logic syncLvl,
  input logic polSel,
  input logic dbEn,
  input logic clearN,
  input logic latched
);

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    !clearN |=> !latched); // R5

  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (latched && clearN) |=> latched); // R6

  AST_SET_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (!latched && (syncLvl != polSel)) |=> !latched); // R1

  AST_DEBOUNCE_TWO: assert property (@(posedge clk) disable iff (!rstN)
    (!latched && dbEn && ($past(syncLvl) != $past(polSel))) |=> !latched); // R4

  AST_POL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (clearN && $past(clearN)) |-> $stable(polSel)); // R9

endmodule

bind fail_latch fail_latch_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .syncLvl(syncLvl),
  .polSel (polSel),
  .dbEn   (dbEn),
  .clearN (clearN),
  .latched(latched)
);

// File: tb/test_fail_latch.sv
module test_fail_latch;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic failLine = 1'b1;
  logic polSel = 1'b0;
  logic dbEn = 1'b0;
  logic clearN = 1'b0;
  logic latched;
  logic irq;

  int checkCnt = 0;
  int failCnt  = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  fail_latch i_fail_latch (
    .clk(clk), .rstN(rstN), .failLine(failLine), .polSel(polSel),
    .dbEn(dbEn), .clearN(clearN), .latched(latched), .irq(irq)
  );

  // Reference model from the requirements: two sync samples, then a
  // one-sample or two-sample qualification, sticky, clear first.
  logic m0, m1, mPrevHit, mLatch;
  function automatic logic nextLatch(logic cur, logic syncd, logic pol,
                                     logic prevHit, logic db, logic clr);
    if (!clr) return 1'b0;
    if (cur) return 1'b1;
    return (syncd == pol) && (!db || prevHit);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      m0 <= 1'b0; m1 <= 1'b0; mPrevHit <= 1'b0; mLatch <= 1'b0;
    end else begin
      m0       <= failLine;
      m1       <= m0;
      mPrevHit <= (m1 == polSel);
      mLatch   <= nextLatch(mLatch, m1, polSel, mPrevHit, dbEn, clearN);
    end
  end

  task automatic chk(input logic act, input logic exp, input string req);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failCnt++;
      $display("FAIL R8 watchdog actual=%0d expected<150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    step(5);
    chk(latched, 1'b0, "R8 latched after reset");
    chk(irq, 1'b0, "R8 irq after reset");
    rstN = 1'b1;
    step(3);

    // R1 / R3: pol 0, no debounce
    clearN = 1'b1;
    step(6);
    chk(latched, 1'b0, "R1 high line ignored with pol 0");
    failLine = 1'b0;
    step(2);
    chk(latched, 1'b0, "R3 not yet after two edges");
    step(1);
    chk(latched, 1'b1, "R1 R3 set after third edge");
    chk(irq, 1'b1, "R7 irq follows latch");
    failLine = 1'b1;
    step(5);
    chk(latched, 1'b1, "R6 stays set after line recovers");
    clearN = 1'b0;
    failLine = 1'b0;
    step(1);
    chk(latched, 1'b0, "R5 clear empties latch");
    step(4);
    chk(latched, 1'b0, "R5 clear beats active level");
    chk(irq, 1'b0, "R7 irq low with latch");

    // R2: pol 1, changed under clear
    polSel = 1'b1;
    step(3);
    clearN = 1'b1;
    step(4);
    chk(latched, 1'b0, "R2 low line ignored with pol 1");
    failLine = 1'b1;
    step(3);
    chk(latched, 1'b1, "R2 high line sets with pol 1");

    // R4: debounce
    clearN = 1'b0;
    failLine = 1'b0;
    dbEn = 1'b1;
    step(4);
    clearN = 1'b1;
    step(2);
    failLine = 1'b1;
    step(1);
    failLine = 1'b0;
    step(6);
    chk(latched, 1'b0, "R4 one-period pulse rejected");
    failLine = 1'b1;
    step(3);
    chk(latched, 1'b0, "R4 not yet after three edges");
    step(1);
    chk(latched, 1'b1, "R4 set after two matching samples");

    // Random phase
    begin
      int unsigned seedVal;
      int clrLeft;
      seedVal = $urandom(32'd4711);
      clrLeft = 0;
      clearN = 1'b0;
      step(2);
      for (int i = 0; i < 4000; i++) begin
        chk(latched, mLatch, "R1 R2 R3 R4 R5 R6 random");
        chk(irq, mLatch, "R7 random");
        if (clrLeft > 0) begin
          clrLeft--;
          if (clrLeft == 0) clearN = 1'b1;
        end else if ($urandom_range(39) == 0) begin
          clearN  = 1'b0;
          clrLeft = 2 + int'($urandom_range(2));
        end
        if (!clearN && clrLeft > 1 && $urandom_range(1) == 1)
          polSel = ~polSel;  // R9: only inside a clear window
        if ($urandom_range(3) == 0) failLine = ~failLine;
        if ($urandom_range(49) == 0) dbEn = ~dbEn;
        step(1);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule